// File: doc/BRIEF.md
# Pipelined Adaptive FIR Error Stage

This block is the forward half of a delayed-update adaptive transversal filter. Each accepted sample enters a tapped delay line. The block then forms the filter output as the inner product of that line with the weight vector presented alongside the sample. It also returns the error between a desired response and that output. The weight-update logic sits outside the block and feeds back new weights through `w_in`.

Each tap's multiplier is a bank of digit decoders. A decoder splits the sample into 2-bit digits, and for each digit an AND-OR selector picks 0, w, 2w or 3w. The most significant digit is signed, so its selector offers w, -2w and -w. The block does not sum each tap's products on their own. Instead it adds all products of equal digit position across the taps in one binary tree per digit. A single shift-add tree then merges the per-digit sums, weighting digit j by 4^j. One register bank follows the digit trees and a second follows the shift-add tree and error stage. This gives a fixed three-cycle latency from the input to the output.

Samples are fixed point with `SAMP_W` bits, of which `SAMP_INT` are integer bits (defaults 16 and 2). Weights, the desired response and the error share one `WGT_W`-bit format (default 16 bits, all fraction). The output keeps full precision.

Top module: `lms_err_pipe`

## Requirements
- R1: When `out_valid` is high, `y_out` equals the sum over k = 0..NTAPS-1 of w_k·x(n-k) as an exact two's-complement integer of ACC_W = SAMP_W+WGT_W+clog2(NTAPS) bits. In this sum, w_k is `w_in[k*WGT_W +: WGT_W]` as presented with sample n, and x(n-k) is the k-th most recent accepted sample, with k = 0 being the newest. The output has SAMP_W-SAMP_INT+weight-fraction fraction bits.
- R2: Samples and weights are signed two's complement, and every extreme combination is exact. This includes the most negative sample with the most negative weight, whose product needs the signed top digit.
- R3: The delay line advances only on cycles with `in_valid` high. Idle cycles between samples insert nothing into the line.
- R4: `out_valid` rises exactly three clock cycles after the `in_valid` cycle it belongs to, and stays low otherwise. Back-to-back inputs give back-to-back results in order.
- R5: `e_out` is the floor of (d·2^(SAMP_W-SAMP_INT) − y) / 2^(SAMP_W-SAMP_INT). Here d is the `d_in` presented with the same sample. This puts the error on the weights' radix point.
- R6: When that error lies outside the signed WGT_W-bit range, `e_out` saturates to 2^(WGT_W-1)−1 or −2^(WGT_W-1).
- R7: `y_out` and `e_out` hold their last values on cycles without a new result.
- R8: Reset clears the delay line, the captured weights and both outputs to zero, and drives `out_valid` low. The first results after reset therefore treat the not-yet-filled taps as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `x_in`, `w_in`, `d_in` |
| x_in | input | SAMP_W | New input sample |
| w_in | input | NTAPS*WGT_W | Weight vector, tap k at bits k*WGT_W upward |
| d_in | input | WGT_W | Desired response, weight format |
| out_valid | output | 1 | Result strobe |
| y_out | output | ACC_W | Full-precision filter output |
| e_out | output | WGT_W | Saturated error, weight format |

## Verification
The bench pairs the most negative sample with the most negative and most positive weights. A design that treats the top digit as unsigned would report a value off by 2^SAMP_W times the weight. A sum width that is too small would wrap the largest output. The bench also drives the desired response hard against large outputs so that the error saturates both ways, where a design missing the clamp would show a wrapped error. Random idle gaps between samples expose a delay line that shifts every cycle, because the older taps would then fill with stale or zero data. A unit impulse after reset must read back each weight in tap order; an index error in the cross-tap transpose would permute them.

// File: rtl/lms_ec_pkg.sv
package lms_ec_pkg;

    // One-hot selection produced by the 2-bit digit decoder.
    typedef struct packed {
        logic pick_one;
        logic pick_two;
        logic pick_three;
    } dig_sel_t;

    // Digit interpretation: lower digits are unsigned, the top digit is signed.
    typedef enum logic {
        DIG_UNSIGNED   = 1'b0,
        DIG_SIGNED_TOP = 1'b1
    } dig_kind_e;

    function automatic dig_sel_t decode_digit(input logic [1:0] u);
        dig_sel_t s;
        s.pick_one   = (u == 2'b01);
        s.pick_two   = (u == 2'b10);
        s.pick_three = (u == 2'b11);
        return s;
    endfunction

    function automatic dig_kind_e kind_of(input int idx, input int ndig);
        return (idx == ndig - 1) ? DIG_SIGNED_TOP : DIG_UNSIGNED;
    endfunction

endpackage

// File: rtl/ec_tap_line.sv
module ec_tap_line #(
    parameter int NTAPS  = 8,
    parameter int SAMP_W = 16,
    parameter int WGT_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  logic [SAMP_W-1:0]                 x_in,
    input  logic [NTAPS*WGT_W-1:0]            w_in,
    input  logic [WGT_W-1:0]                  d_in,
    output logic [NTAPS-1:0][SAMP_W-1:0]      taps,
    output logic [NTAPS-1:0][WGT_W-1:0]       wgt,
    output logic [WGT_W-1:0]                  d_q,
    output logic                              v_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
            wgt  <= '0;
            d_q  <= '0;
            v_q  <= 1'b0;
        end else begin
            v_q <= in_valid;
            if (in_valid) begin
                taps[0] <= x_in;
                for (int k = 1; k < NTAPS; k++) begin
                    taps[k] <= taps[k-1];
                end
                for (int k = 0; k < NTAPS; k++) begin
                    wgt[k] <= w_in[k*WGT_W +: WGT_W];
                end
                d_q <= d_in;
            end
        end
    end

endmodule

// File: rtl/ec_ppg.sv
module ec_ppg
    import lms_ec_pkg::*;
#(
    parameter int SAMP_W = 16,
    parameter int WGT_W  = 16,
    localparam int NDIG  = SAMP_W / 2,
    localparam int PP_W  = WGT_W + 2
) (
    input  logic [SAMP_W-1:0]          x,
    input  logic [WGT_W-1:0]           w,
    output logic [NDIG-1:0][PP_W-1:0]  pp
);

    logic signed [PP_W-1:0] w1, w2, w3, wn1, wn2;

    // Shared multiples: 3w is formed once per tap and reused by every digit.
    always_comb begin
        w1  = PP_W'($signed(w));
        w2  = w1 <<< 1;
        w3  = w1 + w2;
        wn1 = -w1;
        wn2 = -w2;
    end

    for (genvar j = 0; j < NDIG; j++) begin : g_dig
        localparam dig_kind_e KIND = kind_of(j, NDIG);
        dig_sel_t sel;
        logic [PP_W-1:0] op_one, op_two, op_three;

        assign sel = decode_digit(x[2*j +: 2]);

        if (KIND == DIG_SIGNED_TOP) begin : g_top
            // Top digit values: 01 -> +1, 10 -> -2, 11 -> -1
            assign op_one   = w1;
            assign op_two   = wn2;
            assign op_three = wn1;
        end else begin : g_low
            assign op_one   = w1;
            assign op_two   = w2;
            assign op_three = w3;
        end

        // AND-OR selector
        assign pp[j] = ({PP_W{sel.pick_one}}   & op_one)
                     | ({PP_W{sel.pick_two}}   & op_two)
                     | ({PP_W{sel.pick_three}} & op_three);
    end

endmodule

// File: rtl/ec_digit_tree.sv
module ec_digit_tree #(
    parameter int NTERM = 8,
    parameter int IN_W  = 18,
    parameter int OUT_W = 21,
    localparam int PAD  = 1 << $clog2(NTERM),
    localparam int NODES = 2 * PAD - 1
) (
    input  logic [NTERM-1:0][IN_W-1:0] terms,
    output logic [OUT_W-1:0]           sum
);

    // Heap-indexed binary tree: node i adds nodes 2i+1 and 2i+2.
    logic signed [OUT_W-1:0] node [NODES];

    for (genvar i = 0; i < PAD; i++) begin : g_leaf
        if (i < NTERM) begin : g_used
            assign node[PAD-1+i] = OUT_W'($signed(terms[i]));
        end else begin : g_pad
            assign node[PAD-1+i] = '0;
        end
    end

    for (genvar i = 0; i < PAD - 1; i++) begin : g_add
        assign node[i] = node[2*i+1] + node[2*i+2];
    end

    assign sum = node[0];

endmodule

// File: rtl/ec_shift_add.sv
module ec_shift_add #(
    parameter int NDIG  = 8,
    parameter int IN_W  = 21,
    parameter int OUT_W = 35
) (
    input  logic [NDIG-1:0][IN_W-1:0] dsum,
    output logic [OUT_W-1:0]          y
);

    logic [NDIG-1:0][OUT_W-1:0] shifted;

    // Digit j carries weight 4^j.
    for (genvar j = 0; j < NDIG; j++) begin : g_sh
        logic signed [OUT_W-1:0] ext;
        assign ext        = OUT_W'($signed(dsum[j]));
        assign shifted[j] = ext <<< (2 * j);
    end

    ec_digit_tree #(
        .NTERM (NDIG),
        .IN_W  (OUT_W),
        .OUT_W (OUT_W)
    ) u_merge (
        .terms (shifted),
        .sum   (y)
    );

endmodule

// File: rtl/lms_err_pipe.sv
module lms_err_pipe #(
    parameter int NTAPS    = 8,
    parameter int SAMP_W   = 16,
    parameter int SAMP_INT = 2,
    parameter int WGT_W    = 16,
    localparam int NDIG    = SAMP_W / 2,
    localparam int SAMP_FR = SAMP_W - SAMP_INT,
    localparam int PP_W    = WGT_W + 2,
    localparam int TREE_W  = PP_W + $clog2(NTAPS),
    localparam int ACC_W   = SAMP_W + WGT_W + $clog2(NTAPS),
    localparam int DIFF_W  = ACC_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [SAMP_W-1:0]      x_in,
    input  logic [NTAPS*WGT_W-1:0] w_in,
    input  logic [WGT_W-1:0]       d_in,
    output logic                   out_valid,
    output logic [ACC_W-1:0]       y_out,
    output logic [WGT_W-1:0]       e_out
);

    localparam logic signed [DIFF_W-1:0] E_MAX = DIFF_W'((64'sd1 <<< (WGT_W - 1)) - 64'sd1);
    localparam logic signed [DIFF_W-1:0] E_MIN = ~E_MAX;

    // Stage 0: delay line and captured operands
    logic [NTAPS-1:0][SAMP_W-1:0] taps;
    logic [NTAPS-1:0][WGT_W-1:0]  wgt;
    logic [WGT_W-1:0]             d_s0;
    logic                         v_s0;

    ec_tap_line #(
        .NTAPS  (NTAPS),
        .SAMP_W (SAMP_W),
        .WGT_W  (WGT_W)
    ) u_line (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .x_in     (x_in),
        .w_in     (w_in),
        .d_in     (d_in),
        .taps     (taps),
        .wgt      (wgt),
        .d_q      (d_s0),
        .v_q      (v_s0)
    );

    // Partial products per tap, then transposed to per digit
    logic [NTAPS-1:0][NDIG-1:0][PP_W-1:0] pp_tap;
    logic [NDIG-1:0][NTAPS-1:0][PP_W-1:0] pp_dig;
    logic [NDIG-1:0][TREE_W-1:0]          tree_sum;

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        ec_ppg #(
            .SAMP_W (SAMP_W),
            .WGT_W  (WGT_W)
        ) u_ppg (
            .x  (taps[k]),
            .w  (wgt[k]),
            .pp (pp_tap[k])
        );
        for (genvar j = 0; j < NDIG; j++) begin : g_tr
            assign pp_dig[j][k] = pp_tap[k][j];
        end
    end

    for (genvar j = 0; j < NDIG; j++) begin : g_tree
        ec_digit_tree #(
            .NTERM (NTAPS),
            .IN_W  (PP_W),
            .OUT_W (TREE_W)
        ) u_tree (
            .terms (pp_dig[j]),
            .sum   (tree_sum[j])
        );
    end

    // Stage 1: digit sums registered
    logic [NDIG-1:0][TREE_W-1:0] tree_q;
    logic [WGT_W-1:0]            d_s1;
    logic                        v_s1;

    always_ff @(posedge clk) begin
        if (rst) begin
            tree_q <= '0;
            d_s1   <= '0;
            v_s1   <= 1'b0;
        end else begin
            v_s1 <= v_s0;
            if (v_s0) begin
                tree_q <= tree_sum;
                d_s1   <= d_s0;
            end
        end
    end

    // Shift-add merge and error
    logic [ACC_W-1:0] y_comb;

    ec_shift_add #(
        .NDIG  (NDIG),
        .IN_W  (TREE_W),
        .OUT_W (ACC_W)
    ) u_merge (
        .dsum (tree_q),
        .y    (y_comb)
    );

    logic signed [DIFF_W-1:0] d_align, diff, e_wide;
    logic        [WGT_W-1:0]  e_sat;

    always_comb begin
        d_align = DIFF_W'($signed(d_s1)) <<< SAMP_FR;
        diff    = d_align - DIFF_W'($signed(y_comb));
        e_wide  = diff >>> SAMP_FR;
        if (e_wide > E_MAX) begin
            e_sat = E_MAX[WGT_W-1:0];
        end else if (e_wide < E_MIN) begin
            e_sat = E_MIN[WGT_W-1:0];
        end else begin
            e_sat = e_wide[WGT_W-1:0];
        end
    end

    // Stage 2: outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            y_out     <= '0;
            e_out     <= '0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= v_s1;
            if (v_s1) begin
                y_out <= y_comb;
                e_out <= e_sat;
            end
        end
    end

endmodule

// File: rtl/lms_err_pipe_chk.sv
module lms_err_pipe_chk #(
    parameter int NTAPS    = 8,
    parameter int SAMP_W   = 16,
    parameter int SAMP_INT = 2,
    parameter int WGT_W    = 16,
    localparam int SAMP_FR = SAMP_W - SAMP_INT,
    localparam int ACC_W   = SAMP_W + WGT_W + $clog2(NTAPS),
    localparam int DIFF_W  = ACC_W + 1
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [NTAPS*WGT_W-1:0] w_in,
    input logic [WGT_W-1:0]       d_in,
    input logic                   out_valid,
    input logic [ACC_W-1:0]       y_out,
    input logic [WGT_W-1:0]       e_out
);

    localparam logic signed [DIFF_W-1:0] LIM_HI = DIFF_W'((64'sd1 <<< (WGT_W - 1)) - 64'sd1);
    localparam logic signed [DIFF_W-1:0] LIM_LO = ~LIM_HI;

    // Edges seen since reset, saturating at 3
    logic [1:0] seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 2'd0;
        else if (seen != 2'd3) seen <= seen + 2'd1;
    end

    function automatic logic [WGT_W-1:0] err_of(input logic [WGT_W-1:0] d,
                                                input logic [ACC_W-1:0] y);
        logic signed [DIFF_W-1:0] t;
        t = (DIFF_W'($signed(d)) <<< SAMP_FR) - DIFF_W'($signed(y));
        t = t >>> SAMP_FR;
        if (t > LIM_HI) return LIM_HI[WGT_W-1:0];
        if (t < LIM_LO) return LIM_LO[WGT_W-1:0];
        return t[WGT_W-1:0];
    endfunction

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd3 && !$past(in_valid, 3)) |-> ($stable(y_out) && $stable(e_out))); // R7

    AST_ZERO_WEIGHTS: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd3 && $past(in_valid, 3) && $past(w_in, 3) == '0) |-> (y_out == '0)); // R1

    AST_ERROR_SAT: assert property (@(posedge clk) disable iff (rst)
        (seen == 2'd3 && out_valid) |-> (e_out == err_of($past(d_in, 3), y_out))); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && y_out == '0 && e_out == '0)); // R8

endmodule

bind lms_err_pipe lms_err_pipe_chk #(
    .NTAPS    (NTAPS),
    .SAMP_W   (SAMP_W),
    .SAMP_INT (SAMP_INT),
    .WGT_W    (WGT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .w_in      (w_in),
    .d_in      (d_in),
    .out_valid (out_valid),
    .y_out     (y_out),
    .e_out     (e_out)
);

// File: tb/lms_err_pipe_tb.sv
`timescale 1ns/1ps
module lms_err_pipe_tb;

    localparam int NT = 8;
    localparam int LW = 16;
    localparam int LI = 2;
    localparam int WW = 16;
    localparam int SF = LW - LI;
    localparam int AW = LW + WW + $clog2(NT);
    localparam longint EMAX = (64'sd1 <<< (WW - 1)) - 1;
    localparam longint EMIN = -(64'sd1 <<< (WW - 1));

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [LW-1:0]    x_in = '0;
    logic [NT*WW-1:0] w_in = '0;
    logic [WW-1:0]    d_in = '0;
    logic             out_valid;
    logic [AW-1:0]    y_out;
    logic [WW-1:0]    e_out;

    lms_err_pipe #(.NTAPS(NT), .SAMP_W(LW), .SAMP_INT(LI), .WGT_W(WW)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .x_in(x_in), .w_in(w_in),
        .d_in(d_in), .out_valid(out_valid), .y_out(y_out), .e_out(e_out)
    );

    always #2.5 clk = ~clk;

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    longint hist [NT];
    longint q_y[$], q_e[$], q_at[$];
    string  q_ytag[$], q_etag[$];
    string  ytag = "R8";
    string  etag = "R5";
    longint last_y = 0, last_e = 0;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic send(input logic [LW-1:0] x, input logic [NT*WW-1:0] w, input logic [WW-1:0] d);
        longint y, df, e;
        for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = longint'($signed(x));
        y = 0;
        for (int k = 0; k < NT; k++) y += longint'($signed(w[k*WW +: WW])) * hist[k];
        df = (longint'($signed(d)) <<< SF) - y;
        e  = df >>> SF;
        if (e > EMAX) e = EMAX;
        if (e < EMIN) e = EMIN;
        q_y.push_back(y); q_e.push_back(e); q_at.push_back(cyc + 3);
        q_ytag.push_back(ytag); q_etag.push_back(etag);
        in_valid = 1'b1; x_in = x; w_in = w; d_in = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        x_in = $urandom; d_in = $urandom;
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NT*WW-1:0] rand_w(input int shift);
        logic [NT*WW-1:0] v;
        for (int k = 0; k < NT; k++) v[k*WW +: WW] = WW'($signed(16'($urandom)) >>> shift);
        return v;
    endfunction

    function automatic logic [NT*WW-1:0] fill_w(input logic [WW-1:0] val);
        logic [NT*WW-1:0] v;
        for (int k = 0; k < NT; k++) v[k*WW +: WW] = val;
        return v;
    endfunction

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (q_y.size() == 0) begin
                    check("R4", "unexpected out_valid", 1, 0);
                end else begin
                    check("R4", "result cycle", cyc, q_at.pop_front());
                    check(q_ytag.pop_front(), "y_out", longint'($signed(y_out)), q_y.pop_front());
                    check(q_etag.pop_front(), "e_out", longint'($signed(e_out)), q_e.pop_front());
                end
                last_y = longint'($signed(y_out));
                last_e = longint'($signed(e_out));
            end else begin
                check("R7", "y_out hold", longint'($signed(y_out)), last_y);
                check("R7", "e_out hold", longint'($signed(e_out)), last_e);
            end
        end
    end

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [NT*WW-1:0] wv;
        for (int k = 0; k < NT; k++) hist[k] = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: outputs cleared by reset
        check("R8", "out_valid after reset", longint'(out_valid), 0);
        check("R8", "y_out after reset", longint'($signed(y_out)), 0);
        check("R8", "e_out after reset", longint'($signed(e_out)), 0);

        // R8/R1: unit impulse reads weights back in tap order
        for (int k = 0; k < NT; k++) wv[k*WW +: WW] = WW'((k + 1) * 1500 - 6000);
        ytag = "R8"; etag = "R5";
        send(16'h4000, wv, 16'h0100);
        ytag = "R1";
        for (int i = 0; i < NT; i++) send(16'h0000, wv, 16'h0000);
        idle(3);

        // R1/R5: back-to-back random data, small and full-scale
        for (int i = 0; i < 40; i++) begin
            send(LW'($signed(16'($urandom)) >>> ((i % 2) * 6)), rand_w((i % 2) * 5), WW'($urandom));
        end
        idle(4);

        // R2/R6: extreme operands, errors saturate both ways
        ytag = "R2"; etag = "R6";
        send(16'h8000, fill_w(16'h8000), 16'h7FFF);
        send(16'h8000, fill_w(16'h8000), 16'h8000);
        send(16'h8000, fill_w(16'h7FFF), 16'h7FFF);
        send(16'h7FFF, fill_w(16'h8000), 16'h8000);
        send(16'h7FFF, fill_w(16'h7FFF), 16'h0000);
        for (int i = 0; i < NT; i++) send(16'h8000, fill_w(16'h8000), 16'h8000);
        idle(4);

        // R3: random gaps between samples
        ytag = "R3"; etag = "R5";
        for (int i = 0; i < 30; i++) begin
            send(LW'($signed(16'($urandom)) >>> 4), rand_w(4), WW'($signed(16'($urandom)) >>> 2));
            idle(int'($urandom % 5));
        end
        idle(10);

        check("R4", "results outstanding", longint'(q_y.size()), 0);
        done = 1;
        finish_run();
    end

endmodule